// File: doc/BRIEF.md
# Inclusive L2 Snoop Forwarding Filter

This block sits between a shared coherence bus and a single private L1 cache. Only the last-level L2 is attached to the bus. The block holds the L2 tag and coherence-state array. For each line it also keeps one presence bit, which records whether the L1 may hold a copy. Every bus snoop is looked up here, and most of them are answered without involving the L1. A snoop is passed to the L1 only when the presence bit says that the L1 copy could be newer than the L2 state, or when that copy must be removed.

Line states follow a five-state owner/exclusive/modified/shared/invalid scheme. Any read snoop that is passed to the L1 becomes a probe, so an L1 copy that has gone dirty is seen even when the L2 shows only shared or exclusive. A passed read-exclusive snoop becomes an invalidate. A dirty report from the L1 is merged into the L2 line state before the bus is answered. The L2 controller installs lines and changes their state through a local update port. When an install displaces a line that the L1 may hold, the block first back-invalidates that line in the L1 and waits for the acknowledgement, so the L2 always contains everything the L1 holds.

All addresses are line addresses. The low `$clog2(SETS)` bits select the set of a direct-mapped array. The remaining bits form the tag.

Top module: `l2_snoop_filter`

## Requirements
- R1: After reset every line is invalid and has no presence bit. snp_ready and loc_ready are 1, and rsp_valid, l1_req_valid and victim_valid are 0.
- R2: A snoop that misses in the L2 raises no L1 request. It is answered in the cycle after acceptance with rsp_hit=0 and rsp_dirty=0.
- R3: A read snoop that hits a line whose presence bit is clear raises no L1 request. It is answered in the next cycle with rsp_hit=1, and rsp_dirty=1 exactly when the line is M or O. The line then moves M to O and E to S; S and O are unchanged.
- R4: A read-exclusive snoop that hits a line whose presence bit is clear is answered in the next cycle with rsp_hit=1, and rsp_dirty=1 exactly when the line is M or O. The line becomes invalid.
- R5: A read snoop that hits a line whose presence bit is set drives, in the next cycle, l1_req_valid=1 with l1_req_kind=2'b01 (probe) and l1_req_addr equal to the snooped line. The request is held unchanged until l1_ack.
- R6: A read-exclusive snoop that hits a line whose presence bit is set drives l1_req_kind=2'b10 (invalidate). After the acknowledgement the line is invalid and its presence bit is clear.
- R7: For a passed snoop, the bus response appears in the cycle after l1_ack, with rsp_hit=1. rsp_dirty is the OR of l1_ack_dirty and the L2 line being M or O. A dirty probe leaves the line in O with its presence bit still set.
- R8: While an L1 request is outstanding, snp_ready and loc_ready are 0, so at most one request is ever pending.
- R9: A local update that hits an existing line replaces that line's state with loc_state and its presence bit with loc_in_l1.
- R10: A local update that misses, where the set's valid victim has its presence bit set, first drives l1_req_kind=2'b11 (back-invalidate) for the victim line. The new line is installed only after l1_ack. In the next cycle victim_valid=1, and victim_dirty is the OR of the victim being M or O and l1_ack_dirty.
- R11: A local update that misses, where the victim has no presence bit, installs in one cycle with no L1 request. victim_valid pulses in the next cycle if the victim was valid, with victim_dirty=1 exactly when the victim was M or O.
- R12: When a snoop and a local update are offered in the same cycle, loc_ready is 0 and only the snoop takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snp_valid | input | 1 | Bus snoop offered |
| snp_ready | output | 1 | Snoop accepted at this edge when valid |
| snp_excl | input | 1 | 0 = read snoop, 1 = read-exclusive snoop |
| snp_line | input | LINE_W | Snooped line address |
| rsp_valid | output | 1 | One-cycle bus response pulse |
| rsp_hit | output | 1 | A cached copy existed |
| rsp_dirty | output | 1 | The copy was dirty (owner supplies data) |
| l1_req_valid | output | 1 | Request to the L1 pending |
| l1_req_kind | output | 2 | 01 probe, 10 invalidate, 11 back-invalidate |
| l1_req_line | output | LINE_W | Line the L1 request refers to |
| l1_ack | input | 1 | L1 has completed the request |
| l1_ack_dirty | input | 1 | L1 copy was dirty |
| loc_valid | input | 1 | Local state update or install offered |
| loc_ready | output | 1 | Local update accepted at this edge when valid |
| loc_line | input | LINE_W | Line to update or install |
| loc_state | input | 3 | New state: 0 I, 1 S, 2 E, 3 O, 4 M |
| loc_in_l1 | input | 1 | Line is also held by the L1 |
| victim_valid | output | 1 | One-cycle pulse: a valid line was displaced |
| victim_dirty | output | 1 | The displaced line needs a write-back |

## Verification
On every cycle the assertions check that at most one L1 request is outstanding with both inputs stalled, and that a pending request stays stable. They also check that every response and victim pulse can be traced to an accepted operation or an acknowledgement, that a dirty response always reports a hit, and that no presence bit sits on an invalid line. The state transitions are checked only by the bench scenarios. This covers M to O on a read, merging a dirty probe reply, a tag alias in the same set, the back-invalidate ordering on eviction, and the rule that a snoop wins over a local update, each observed through later snoop responses.

// File: rtl/l2_snoop_filter.sv
module l2_snoop_filter #(
  parameter int LINE_W = 10,
  parameter int SETS   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  output logic              snp_ready,
  input  logic              snp_excl,
  input  logic [LINE_W-1:0] snp_line,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_dirty,
  output logic              l1_req_valid,
  output logic [1:0]        l1_req_kind,
  output logic [LINE_W-1:0] l1_req_line,
  input  logic              l1_ack,
  input  logic              l1_ack_dirty,
  input  logic              loc_valid,
  output logic              loc_ready,
  input  logic [LINE_W-1:0] loc_line,
  input  logic [2:0]        loc_state,
  input  logic              loc_in_l1,
  output logic              victim_valid,
  output logic              victim_dirty
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = LINE_W - IDX_W;

  localparam logic [2:0] CS_I = 3'd0;
  localparam logic [2:0] CS_S = 3'd1;
  localparam logic [2:0] CS_E = 3'd2;
  localparam logic [2:0] CS_O = 3'd3;
  localparam logic [2:0] CS_M = 3'd4;

  localparam logic [1:0] K_PROBE = 2'b01;
  localparam logic [1:0] K_INV   = 2'b10;
  localparam logic [1:0] K_BINV  = 2'b11;

  typedef enum logic [1:0] {PH_IDLE, PH_SNOOP, PH_EVICT} phase_t;

  phase_t             phase;
  logic [2:0]         lstate [SETS];
  logic [TAG_W-1:0]   ltag   [SETS];
  logic [SETS-1:0]    pres;
  logic [SETS-1:0]    live;

  logic [IDX_W-1:0]   hold_idx;
  logic [TAG_W-1:0]   hold_tag;
  logic [2:0]         hold_state;
  logic               hold_in_l1;
  logic               hold_excl;

  function automatic logic is_dirty(input logic [2:0] s);
    return (s == CS_M) || (s == CS_O);
  endfunction

  function automatic logic [2:0] after_read(input logic [2:0] s);
    case (s)
      CS_M:    return CS_O;
      CS_E:    return CS_S;
      default: return s;
    endcase
  endfunction

  wire [IDX_W-1:0] s_idx = snp_line[IDX_W-1:0];
  wire [TAG_W-1:0] s_tag = snp_line[LINE_W-1:IDX_W];
  wire             s_hit = live[s_idx] && (ltag[s_idx] == s_tag);
  wire             s_fwd = s_hit && pres[s_idx];

  wire [IDX_W-1:0] l_idx = loc_line[IDX_W-1:0];
  wire [TAG_W-1:0] l_tag = loc_line[LINE_W-1:IDX_W];
  wire             l_hit = live[l_idx] && (ltag[l_idx] == l_tag);

  assign snp_ready = (phase == PH_IDLE);
  assign loc_ready = (phase == PH_IDLE) && !snp_valid;

  wire snp_go = snp_valid && snp_ready;
  wire loc_go = loc_valid && loc_ready;

  always_comb begin
    for (int i = 0; i < SETS; i++) live[i] = (lstate[i] != CS_I);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase        <= PH_IDLE;
      pres         <= '0;
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_dirty    <= 1'b0;
      l1_req_valid <= 1'b0;
      l1_req_kind  <= 2'b00;
      l1_req_line  <= '0;
      victim_valid <= 1'b0;
      victim_dirty <= 1'b0;
      hold_idx     <= '0;
      hold_tag     <= '0;
      hold_state   <= CS_I;
      hold_in_l1   <= 1'b0;
      hold_excl    <= 1'b0;
      for (int i = 0; i < SETS; i++) begin
        lstate[i] <= CS_I;
        ltag[i]   <= '0;
      end
    end else begin
      rsp_valid    <= 1'b0;
      victim_valid <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (snp_go) begin
            if (!s_hit) begin
              rsp_valid <= 1'b1;
              rsp_hit   <= 1'b0;
              rsp_dirty <= 1'b0;
            end else if (!s_fwd) begin
              rsp_valid      <= 1'b1;
              rsp_hit        <= 1'b1;
              rsp_dirty      <= is_dirty(lstate[s_idx]);
              lstate[s_idx]  <= snp_excl ? CS_I : after_read(lstate[s_idx]);
            end else begin
              phase        <= PH_SNOOP;
              l1_req_valid <= 1'b1;
              l1_req_kind  <= snp_excl ? K_INV : K_PROBE;
              l1_req_line  <= snp_line;
              hold_idx     <= s_idx;
              hold_excl    <= snp_excl;
            end
          end else if (loc_go) begin
            if (l_hit) begin
              lstate[l_idx] <= loc_state;
              pres[l_idx]   <= loc_in_l1;
            end else if (live[l_idx] && pres[l_idx]) begin
              phase        <= PH_EVICT;
              l1_req_valid <= 1'b1;
              l1_req_kind  <= K_BINV;
              l1_req_line  <= {ltag[l_idx], l_idx};
              hold_idx     <= l_idx;
              hold_tag     <= l_tag;
              hold_state   <= loc_state;
              hold_in_l1   <= loc_in_l1;
            end else begin
              victim_valid  <= live[l_idx];
              victim_dirty  <= is_dirty(lstate[l_idx]);
              lstate[l_idx] <= loc_state;
              ltag[l_idx]   <= l_tag;
              pres[l_idx]   <= loc_in_l1;
            end
          end
        end
        PH_SNOOP: begin
          if (l1_ack) begin
            phase        <= PH_IDLE;
            l1_req_valid <= 1'b0;
            rsp_valid    <= 1'b1;
            rsp_hit      <= 1'b1;
            rsp_dirty    <= l1_ack_dirty || is_dirty(lstate[hold_idx]);
            if (hold_excl) begin
              lstate[hold_idx] <= CS_I;
              pres[hold_idx]   <= 1'b0;
            end else begin
              lstate[hold_idx] <= after_read(l1_ack_dirty ? CS_M : lstate[hold_idx]);
            end
          end
        end
        PH_EVICT: begin
          if (l1_ack) begin
            phase            <= PH_IDLE;
            l1_req_valid     <= 1'b0;
            victim_valid     <= 1'b1;
            victim_dirty     <= l1_ack_dirty || is_dirty(lstate[hold_idx]);
            lstate[hold_idx] <= hold_state;
            ltag[hold_idx]   <= hold_tag;
            pres[hold_idx]   <= hold_in_l1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assert_one_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_n)
    l1_req_valid |-> (!snp_ready && !loc_ready));

  assert_req_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_req_valid && !l1_ack) |=> (l1_req_valid && $stable(l1_req_line) && $stable(l1_req_kind)));

  assert_req_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(l1_req_valid) && l1_req_kind != K_BINV) |-> $past(snp_valid && snp_ready));

  assert_rsp_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(snp_valid && snp_ready) ||
                   $past(l1_ack && l1_req_valid && l1_req_kind != K_BINV)));

  assert_dirty_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_dirty) |-> rsp_hit);

  assert_victim_origin_R11: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |-> ($past(loc_valid && loc_ready) ||
                      $past(l1_ack && l1_req_valid && l1_req_kind == K_BINV)));

  assert_inclusion_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pres & ~live) == '0);

endmodule

// File: tb/l2_snoop_filter_bench.sv
`timescale 1ns/1ps
module l2_snoop_filter_bench;
  localparam int LW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic snp_valid = 0, snp_excl = 0;
  logic [LW-1:0] snp_line = '0;
  logic rsp_valid, rsp_hit, rsp_dirty, snp_ready;
  logic l1_req_valid;
  logic [1:0] l1_req_kind;
  logic [LW-1:0] l1_req_line;
  logic l1_ack = 0, l1_ack_dirty = 0;
  logic loc_valid = 0, loc_in_l1 = 0, loc_ready;
  logic [LW-1:0] loc_line = '0;
  logic [2:0] loc_state = '0;
  logic victim_valid, victim_dirty;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  l2_snoop_filter #(.LINE_W(LW), .SETS(8)) u_l2_snoop_filter (
    .clk(clk), .rst_n(rst_n),
    .snp_valid(snp_valid), .snp_ready(snp_ready), .snp_excl(snp_excl), .snp_line(snp_line),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_dirty(rsp_dirty),
    .l1_req_valid(l1_req_valid), .l1_req_kind(l1_req_kind), .l1_req_line(l1_req_line),
    .l1_ack(l1_ack), .l1_ack_dirty(l1_ack_dirty),
    .loc_valid(loc_valid), .loc_ready(loc_ready), .loc_line(loc_line),
    .loc_state(loc_state), .loc_in_l1(loc_in_l1),
    .victim_valid(victim_valid), .victim_dirty(victim_dirty)
  );

  typedef struct packed {
    logic          excl;
    logic [LW-1:0] line;
    logic          fwd;
    logic [1:0]    kind;
    logic          ackd;
    logic          hit;
    logic          dirty;
    logic [3:0]    req;
  } vec_t;

  // Loaded beforehand: line 1 M, 2 E, 3 S+L1, 4 E+L1, 5 O (no L1 unless noted)
  localparam vec_t VECS [14] = '{
    '{1'b0, 10'd1,   1'b0, 2'b00, 1'b0, 1'b1, 1'b1, 4'd3},  // R3 read M
    '{1'b0, 10'd1,   1'b0, 2'b00, 1'b0, 1'b1, 1'b1, 4'd3},  // R3 now O
    '{1'b1, 10'd1,   1'b0, 2'b00, 1'b0, 1'b1, 1'b1, 4'd4},  // R4 readx O
    '{1'b0, 10'd1,   1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 gone
    '{1'b0, 10'd2,   1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 read E
    '{1'b1, 10'd2,   1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 4'd4},  // R4 readx S
    '{1'b0, 10'd3,   1'b1, 2'b01, 1'b1, 1'b1, 1'b1, 4'd7},  // R7 dirty probe on S
    '{1'b0, 10'd3,   1'b1, 2'b01, 1'b0, 1'b1, 1'b1, 4'd7},  // R7 merged to O
    '{1'b1, 10'd3,   1'b1, 2'b10, 1'b0, 1'b1, 1'b1, 4'd6},  // R6 invalidate
    '{1'b0, 10'd3,   1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 line dropped
    '{1'b1, 10'd4,   1'b1, 2'b10, 1'b1, 1'b1, 1'b1, 4'd6},  // R6 dirty L1 on E
    '{1'b0, 10'd4,   1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
    '{1'b0, 10'h085, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 tag alias set 5
    '{1'b0, 10'd5,   1'b0, 2'b00, 1'b0, 1'b1, 1'b1, 4'd3}   // R3 read O
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic loc_op(input logic [LW-1:0] ln, input logic [2:0] st, input logic inl1);
    loc_valid = 1; loc_line = ln; loc_state = st; loc_in_l1 = inl1;
    tick();
    loc_valid = 0;
  endtask

  task automatic snoop(input string req, input logic ex, input logic [LW-1:0] ln,
                       input logic fwd, input logic [1:0] kind, input logic ackd,
                       input logic hit, input logic dirty);
    snp_valid = 1; snp_excl = ex; snp_line = ln;
    tick();
    snp_valid = 0;
    chk({req, " l1_req_valid"}, l1_req_valid, fwd);
    if (fwd) begin
      chk({req, " l1_req_kind"}, l1_req_kind, kind);
      chk({req, " l1_req_line"}, l1_req_line, ln);
      chk({req, " no early rsp"}, rsp_valid, 0);
      l1_ack = 1; l1_ack_dirty = ackd;
      tick();
      l1_ack = 0; l1_ack_dirty = 0;
      chk({req, " req dropped"}, l1_req_valid, 0);
    end
    chk({req, " rsp_valid"}, rsp_valid, 1);
    chk({req, " rsp_hit"}, rsp_hit, hit);
    chk({req, " rsp_dirty"}, rsp_dirty, dirty);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 snp_ready", snp_ready, 1);
    chk("R1 loc_ready", loc_ready, 1);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 l1_req_valid", l1_req_valid, 0);
    chk("R1 victim_valid", victim_valid, 0);
    snoop("R1 empty", 0, 10'd0, 0, 2'b00, 0, 0, 0);

    loc_op(10'd1, 3'd4, 0);
    loc_op(10'd2, 3'd2, 0);
    loc_op(10'd3, 3'd1, 1);
    loc_op(10'd4, 3'd2, 1);
    loc_op(10'd5, 3'd3, 0);
    chk("R11 install empty set", victim_valid, 0);

    for (int i = 0; i < 14; i++) begin
      string tagname;
      tagname = $sformatf("R%0d vec%0d", VECS[i].req, i);
      snoop(tagname, VECS[i].excl, VECS[i].line, VECS[i].fwd, VECS[i].kind,
            VECS[i].ackd, VECS[i].hit, VECS[i].dirty);
    end

    // R8 stall while a probe is outstanding
    loc_op(10'd7, 3'd1, 1);
    snp_valid = 1; snp_excl = 0; snp_line = 10'd7;
    tick();
    snp_excl = 1; snp_line = 10'd5;
    chk("R8 probe issued", l1_req_valid, 1);
    for (int k = 0; k < 3; k++) begin
      chk("R8 snp_ready low", snp_ready, 0);
      chk("R8 loc_ready low", loc_ready, 0);
      chk("R8 no rsp while waiting", rsp_valid, 0);
      chk("R5 request held", {l1_req_valid, l1_req_kind, l1_req_line}, {1'b1, 2'b01, 10'd7});
      tick();
    end
    l1_ack = 1; l1_ack_dirty = 0;
    tick();
    l1_ack = 0;
    chk("R7 clean probe rsp", {rsp_valid, rsp_hit, rsp_dirty}, 3'b110);
    chk("R8 ready again", snp_ready, 1);
    tick();
    snp_valid = 0;
    chk("R8 stalled snoop served", {rsp_valid, rsp_hit, rsp_dirty}, 3'b111);
    snoop("R4 stalled readx left I", 0, 10'd5, 0, 2'b00, 0, 0, 0);

    // R9 update hit replaces state and presence
    loc_op(10'd7, 3'd4, 0);
    snoop("R9 update hit", 0, 10'd7, 0, 2'b00, 0, 1, 1);

    // R10 back-invalidate before install
    loc_op(10'd8, 3'd2, 1);
    loc_valid = 1; loc_line = 10'd0; loc_state = 3'd1; loc_in_l1 = 0;
    tick();
    loc_valid = 0;
    chk("R10 back-invalidate", {l1_req_valid, l1_req_kind, l1_req_line}, {1'b1, 2'b11, 10'd8});
    chk("R10 no victim yet", victim_valid, 0);
    chk("R10 loc_ready low", loc_ready, 0);
    l1_ack = 1; l1_ack_dirty = 1;
    tick();
    l1_ack = 0; l1_ack_dirty = 0;
    chk("R10 victim after ack", {victim_valid, victim_dirty, l1_req_valid}, 3'b110);
    snoop("R10 victim gone", 0, 10'd8, 0, 2'b00, 0, 0, 0);
    snoop("R10 new line", 0, 10'd0, 0, 2'b00, 0, 1, 0);

    // R11 eviction without presence
    loc_op(10'd16, 3'd4, 0);
    chk("R11 silent evict", {victim_valid, victim_dirty, l1_req_valid}, 3'b100);
    snoop("R11 installed", 1, 10'd16, 0, 2'b00, 0, 1, 1);
    snoop("R11 old gone", 0, 10'd0, 0, 2'b00, 0, 0, 0);

    // R12 snoop wins over local update
    snp_valid = 1; snp_excl = 0; snp_line = 10'd6;
    loc_valid = 1; loc_line = 10'd6; loc_state = 3'd4; loc_in_l1 = 1;
    #1;
    chk("R12 loc_ready low", loc_ready, 0);
    tick();
    snp_valid = 0; loc_valid = 0;
    chk("R12 snoop served", {rsp_valid, rsp_hit}, 2'b10);
    snoop("R12 update dropped", 0, 10'd6, 0, 2'b00, 0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule